// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a compact processor built around one 16-bit accumulator. It fetches 16-bit instructions from an external 256-word by 16-bit synchronous memory and executes them one at a time. Each instruction word carries an operation code in its upper byte and a memory address, or an unused byte, in its lower byte. Arithmetic and logic operations combine the accumulator with the word stored at that address and leave the result in the accumulator. Further instructions load, store, jump unconditionally, jump when the accumulator is non-negative, and stop the machine.

The core holds a program counter, a memory address register, a memory buffer register, an instruction register, the accumulator and an operand register. A sequencer steps through a fixed number of states for each instruction class. The memory port is a plain synchronous single-port array interface. The memory samples its address on every rising edge and returns the stored word one cycle later. A write takes place on the edge that ends a cycle with the write enable high. There is no flow control on this port: the memory is always ready and has fixed latency. The accumulator value and a halted flag are exposed for observation.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator is cleared, the halted flag drops and the next instruction is fetched from address 0; a halted core restarts this way.
- R2: An instruction word holds the operation code in bits 15..8 and the address in bits 7..0. Instructions run in address order with the program counter advancing by one (modulo 256) unless a jump is taken.
- R3: Codes 0x01 add, 0x02 subtract, 0x08 multiply and 0x09 divide apply to the accumulator and the word at the address. The result is unsigned and modulo 2^16; the product keeps its low 16 bits, and a zero divisor gives 0xFFFF.
- R4: Code 0x03 ANDs and code 0x04 ORs the accumulator with the word at the address. Code 0x05 writes the bitwise complement of that word into the accumulator.
- R5: Code 0x06 shifts the accumulator right by one and code 0x07 shifts it left by one, both logical with zero fill. The address byte is ignored.
- R6: Code 0x0E copies the word at the address into the accumulator. Code 0x0D writes the accumulator to the address with a write enable that stays high for exactly one cycle. No other instruction writes memory.
- R7: Code 0x0B always loads the address into the program counter. Code 0x0A does so only when accumulator bit 15 is 0, and otherwise falls through to the next word.
- R8: Code 0x0C raises `halted` and keeps it high until reset. While halted, no memory write happens and the accumulator does not change.
- R9: Codes 0x00 and 0x0F through 0xFF change nothing except advancing the program counter.
- R10: Counted in rising edges from the instruction's first cycle, the memory-operand instructions (0x01–0x05, 0x08, 0x09, 0x0E) update the accumulator on edge 6. The shifts update it on edge 4. A store raises the write enable during cycle 5. Jumps take 4 cycles, no-operations take 3 cycles, and the halt flag rises on edge 3.
- R11: A program that sums 1 to 100 in a loop with a conditional jump stops with 5050 (0x13BA) in the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory word address, sampled by the memory every edge |
| mem_wdata | output | 16 | Data to write |
| mem_we | output | 1 | Write enable for the current cycle |
| mem_rdata | input | 16 | Word read at the address of the previous edge |
| acc_out | output | 16 | Current accumulator value |
| halted | output | 1 | High once a halt instruction has run, until reset |

## Verification
The bench compares the accumulator, the halted flag and the write enable with an instruction-level reference model on every clock. Any fault in the sequencer or the datapath registers therefore shows at the ports within one instruction time: a wrong operand, a wrong opcode decode or a wrong state count moves or corrupts the accumulator update on the predicted edge. A corrupted program counter or address register shows later, as a wrong instruction stream that changes the accumulator or the final memory image. After each run, the memory contents are compared word by word with the model.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OP_W = 8;

  localparam logic [OP_W-1:0] OPC_ADD    = 8'h01;
  localparam logic [OP_W-1:0] OPC_SUB    = 8'h02;
  localparam logic [OP_W-1:0] OPC_AND    = 8'h03;
  localparam logic [OP_W-1:0] OPC_OR     = 8'h04;
  localparam logic [OP_W-1:0] OPC_NOT    = 8'h05;
  localparam logic [OP_W-1:0] OPC_SHR    = 8'h06;
  localparam logic [OP_W-1:0] OPC_SHL    = 8'h07;
  localparam logic [OP_W-1:0] OPC_MUL    = 8'h08;
  localparam logic [OP_W-1:0] OPC_DIV    = 8'h09;
  localparam logic [OP_W-1:0] OPC_JGEZ   = 8'h0A;
  localparam logic [OP_W-1:0] OPC_JMP    = 8'h0B;
  localparam logic [OP_W-1:0] OPC_HALT   = 8'h0C;
  localparam logic [OP_W-1:0] OPC_STORE  = 8'h0D;
  localparam logic [OP_W-1:0] OPC_LOAD   = 8'h0E;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOT,
    ALU_SHR, ALU_SHL, ALU_MUL, ALU_DIV, ALU_PASSB
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_FETCH,   // address register takes the program counter
    ST_FREAD,   // memory reads the instruction
    ST_DECODE,  // instruction captured, program counter advances
    ST_OPREAD,  // memory reads the operand
    ST_LDBR,    // operand register captures the operand
    ST_EXEC,    // accumulator takes the ALU result
    ST_STACC,   // buffer register takes the accumulator
    ST_WRITE,   // memory write
    ST_JUMP,    // program counter may take the target
    ST_HALT     // frozen until reset
  } state_e;

  typedef struct packed {
    logic    mar_pc;    // MAR <= PC
    logic    dec_load;  // IR, MAR, MBR <= instruction, PC <= PC + 1
    logic    br_load;   // BR <= memory word
    logic    mbr_acc;   // MBR <= ACC
    logic    pc_load;   // PC <= target in MBR
    logic    acc_load;  // ACC <= ALU result
    logic    mem_we;    // write MBR to memory at MAR
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_NOT:   y = ~b;
      ALU_SHR:   y = a >> 1;
      ALU_SHL:   y = a << 1;
      ALU_MUL:   y = a * b;
      ALU_DIV:   y = (b == '0) ? '1 : a / b;
      ALU_PASSB: y = b;
      default:   y = b;
    endcase
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_in,   // opcode on the memory read bus
  input  logic [OP_W-1:0] ir,      // latched opcode
  input  logic            acc_neg,
  output ctrl_t           ctrl,
  output logic            halted
);

  state_e state, state_nx;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= state_nx;
  end

  // next state
  always_comb begin
    state_nx = state;
    unique case (state)
      ST_FETCH:  state_nx = ST_FREAD;
      ST_FREAD:  state_nx = ST_DECODE;
      ST_DECODE: begin
        unique case (op_in)
          OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_NOT,
          OPC_MUL, OPC_DIV, OPC_LOAD: state_nx = ST_OPREAD;
          OPC_SHR, OPC_SHL:           state_nx = ST_EXEC;
          OPC_STORE:                  state_nx = ST_STACC;
          OPC_JMP, OPC_JGEZ:          state_nx = ST_JUMP;
          OPC_HALT:                   state_nx = ST_HALT;
          default:                    state_nx = ST_FETCH;
        endcase
      end
      ST_OPREAD: state_nx = ST_LDBR;
      ST_LDBR:   state_nx = ST_EXEC;
      ST_EXEC:   state_nx = ST_FETCH;
      ST_STACC:  state_nx = ST_WRITE;
      ST_WRITE:  state_nx = ST_FETCH;
      ST_JUMP:   state_nx = ST_FETCH;
      ST_HALT:   state_nx = ST_HALT;
      default:   state_nx = ST_FETCH;
    endcase
  end

  // ALU selection from the latched opcode
  alu_op_e alu_sel;
  always_comb begin
    unique case (ir)
      OPC_ADD: alu_sel = ALU_ADD;
      OPC_SUB: alu_sel = ALU_SUB;
      OPC_AND: alu_sel = ALU_AND;
      OPC_OR:  alu_sel = ALU_OR;
      OPC_NOT: alu_sel = ALU_NOT;
      OPC_SHR: alu_sel = ALU_SHR;
      OPC_SHL: alu_sel = ALU_SHL;
      OPC_MUL: alu_sel = ALU_MUL;
      OPC_DIV: alu_sel = ALU_DIV;
      default: alu_sel = ALU_PASSB;
    endcase
  end

  // control word
  always_comb begin
    ctrl          = '0;
    ctrl.alu_op   = alu_sel;
    ctrl.mar_pc   = (state == ST_FETCH);
    ctrl.dec_load = (state == ST_DECODE);
    ctrl.br_load  = (state == ST_LDBR);
    ctrl.acc_load = (state == ST_EXEC);
    ctrl.mbr_acc  = (state == ST_STACC);
    ctrl.mem_we   = (state == ST_WRITE);
    ctrl.pc_load  = (state == ST_JUMP) && ((ir == OPC_JMP) || !acc_neg);
  end

  assign halted = (state == ST_HALT);

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_y,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [OP_W-1:0]   ir,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] br
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      br  <= '0;
    end else begin
      if (ctrl.mar_pc)
        mar <= pc;
      if (ctrl.dec_load) begin
        ir  <= mem_rdata[DATA_W-1 -: OP_W];
        mar <= mem_rdata[ADDR_W-1:0];
        mbr <= mem_rdata;
      end
      if (ctrl.mbr_acc)
        mbr <= acc;
      if (ctrl.pc_load)
        pc <= mbr[ADDR_W-1:0];
      else if (ctrl.dec_load)
        pc <= pc + 1'b1;
      if (ctrl.br_load)
        br <= mem_rdata;
      if (ctrl.acc_load)
        acc <= alu_y;
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [OP_W+ADDR_W-1:0] mem_wdata,
  output logic                   mem_we,
  input  logic [OP_W+ADDR_W-1:0] mem_rdata,
  output logic [OP_W+ADDR_W-1:0] acc_out,
  output logic                   halted
);

  localparam int unsigned DATA_W = OP_W + ADDR_W;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, acc, br, alu_y;
  logic [OP_W-1:0]   ir;

  acc_cpu_seq i_seq (
    .clk     (clk),
    .rst     (rst),
    .op_in   (mem_rdata[DATA_W-1 -: OP_W]),
    .ir      (ir),
    .acc_neg (acc[DATA_W-1]),
    .ctrl    (ctrl),
    .halted  (halted)
  );

  acc_cpu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .alu_y     (alu_y),
    .pc        (pc),
    .mar       (mar),
    .mbr       (mbr),
    .ir        (ir),
    .acc       (acc),
    .br        (br)
  );

  acc_cpu_alu #(.W(DATA_W)) i_alu (
    .a  (acc),
    .b  (br),
    .op (ctrl.alu_op),
    .y  (alu_y)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = ctrl.mem_we;
  assign acc_out   = acc;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] acc_out,
  input logic              halted
);

  // R1: reset clears the accumulator and the halt flag
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && !halted));

  // R6: a store writes the accumulator value
  p_store_data_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc_out));

  // R6: write enable lasts a single cycle
  p_write_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R8: halt is sticky until reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R8: no write while halted
  p_halt_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R8: accumulator frozen while halted
  p_halt_acc_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(acc_out));

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .acc_out   (acc_out),
  .halted    (halted)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_q = 1'b1;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata = '0;
  logic [15:0] acc_out;
  logic        halted;

  int tests = 0;
  int fails = 0;

  logic [15:0] mem     [256];
  logic [15:0] ref_mem [256];

  // reference model state
  logic [7:0]  ref_pc   = '0;
  logic [15:0] ref_acc  = '0;
  logic        ref_halt = 1'b0;
  logic        exp_we   = 1'b0;
  logic [15:0] cur      = '0;
  int          cnt      = 0;
  int          lat      = 3;
  string       last_tag = "R1";

  acc_cpu_core i_acc_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .acc_out   (acc_out),
    .halted    (halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous single-port memory
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) rst_q <= rst;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10: cycle counts per instruction class
  function automatic int latency(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h08, 8'h09, 8'h0E: return 6;
      8'h06, 8'h07, 8'h0A, 8'h0B: return 4;
      8'h0D: return 5;
      default: return 3;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h08, 8'h09: return "R3";
      8'h03, 8'h04, 8'h05:        return "R4";
      8'h06, 8'h07:               return "R5";
      8'h0D, 8'h0E:               return "R6";
      8'h0A, 8'h0B:               return "R7";
      8'h0C:                      return "R8";
      default:                    return "R9";
    endcase
  endfunction

  task automatic model_apply(input logic [15:0] w);
    logic [7:0]  op = w[15:8];
    logic [7:0]  x  = w[7:0];
    logic [15:0] b  = ref_mem[x];
    ref_pc = ref_pc + 8'd1;                        // R2
    case (op)
      8'h01: ref_acc = ref_acc + b;
      8'h02: ref_acc = ref_acc - b;
      8'h03: ref_acc = ref_acc & b;
      8'h04: ref_acc = ref_acc | b;
      8'h05: ref_acc = ~b;
      8'h06: ref_acc = {1'b0, ref_acc[15:1]};
      8'h07: ref_acc = {ref_acc[14:0], 1'b0};
      8'h08: ref_acc = 16'((32'(ref_acc) * 32'(b)) & 32'hFFFF);
      8'h09: ref_acc = (b == 16'd0) ? 16'hFFFF : ref_acc / b;
      8'h0A: if (!ref_acc[15]) ref_pc = x;
      8'h0B: ref_pc = x;
      8'h0C: ref_halt = 1'b1;
      8'h0D: ref_mem[x] = ref_acc;
      8'h0E: ref_acc = b;
      default: ;
    endcase
    last_tag = tag_of(op);
  endtask

  // model advances one edge per cycle and is compared away from the edge
  always @(negedge clk) begin
    if (rst_q) begin
      ref_pc = '0; ref_acc = '0; ref_halt = 1'b0; cnt = 0; last_tag = "R1";
    end else if (!ref_halt) begin
      if (cnt == 0) begin
        cur = ref_mem[ref_pc];
        lat = latency(cur[15:8]);
      end
      cnt++;
      if (cnt == lat) begin
        model_apply(cur);
        cnt = 0;
      end
    end
    exp_we = !rst_q && !ref_halt && cnt == 4 && cur[15:8] == 8'h0D;
    chk({last_tag, "/R10 acc"}, 32'(acc_out), 32'(ref_acc));
    chk({last_tag, "/R10 halted"}, 32'(halted), 32'(ref_halt));
    chk("R6/R10 write enable", 32'(mem_we), 32'(exp_we));
  end

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    mem[a] = w;
    ref_mem[a] = w;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) put(8'(i), 16'h0000);
  endtask

  task automatic run_until_halt(input int max_cycles, input string tag);
    int n = 0;
    while (!halted && n < max_cycles) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      tests++; fails++;
      $display("FAIL %s watchdog actual=running expected=halted", tag);
    end
  endtask

  task automatic compare_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++)
      if (mem[i] !== ref_mem[i]) bad++;
    chk(tag, 32'(bad), 32'd0);
  endtask

  initial begin
    // global watchdog
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // program exercising every instruction class
    clear_mem();
    put(8'h00, 16'h0E80);  // LOAD  0x1234
    put(8'h01, 16'h0181);  // ADD   wraps (R3)
    put(8'h02, 16'h0282);  // SUB   wraps
    put(8'h03, 16'h0383);  // AND   (R4)
    put(8'h04, 16'h0484);  // OR
    put(8'h05, 16'h0585);  // NOT
    put(8'h06, 16'h0655);  // SHR, address byte ignored (R5)
    put(8'h07, 16'h0700);  // SHL
    put(8'h08, 16'h0D90);  // STORE (R6)
    put(8'h09, 16'h0E86);  // LOAD 7
    put(8'h0A, 16'h0887);  // MPY truncates
    put(8'h0B, 16'h0988);  // DIV by 3
    put(8'h0C, 16'h0989);  // DIV by 0 -> FFFF
    put(8'h0D, 16'h0A30);  // JMPGEZ negative: not taken (R7)
    put(8'h0E, 16'h0000);  // no-ops (R9)
    put(8'h0F, 16'h3F12);
    put(8'h10, 16'hFFFF);
    put(8'h11, 16'h0B20);  // JMP
    put(8'h12, 16'h0D91);  // skipped
    put(8'h20, 16'h0E86);  // LOAD 7
    put(8'h21, 16'h0A28);  // JMPGEZ positive: taken
    put(8'h22, 16'h0D92);  // skipped
    put(8'h28, 16'h0E8A);  // LOAD 0
    put(8'h29, 16'h0A2C);  // JMPGEZ zero: taken
    put(8'h2A, 16'h0D93);  // skipped
    put(8'h2C, 16'h0E90);
    put(8'h2D, 16'h0186);
    put(8'h2E, 16'h0D94);
    put(8'h2F, 16'h0C00);  // HALT (R8)
    put(8'h30, 16'h0D95);  // never reached
    put(8'h80, 16'h1234);
    put(8'h81, 16'hF00F);
    put(8'h82, 16'h0500);
    put(8'h83, 16'h0FF0);
    put(8'h84, 16'h8001);
    put(8'h85, 16'h00FF);
    put(8'h86, 16'h0007);
    put(8'h87, 16'h3000);
    put(8'h88, 16'h0003);
    put(8'h89, 16'h0000);
    put(8'h8A, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R1 reset acc", 32'(acc_out), 32'd0);
    chk("R1 reset halted", 32'(halted), 32'd0);
    rst = 1'b0;
    run_until_halt(2000, "R8");
    repeat (30) @(negedge clk);
    chk("R8 halted held", 32'(halted), 32'd1);
    compare_mem("R2/R6 memory image");
    chk("R7 skipped store", 32'(mem[8'h91] | mem[8'h92] | mem[8'h93]), 32'd0);
    chk("R8 no write after halt", 32'(mem[8'h95]), 32'd0);

    // sum 1..100 after reset from the halted state
    rst = 1'b1;
    clear_mem();
    put(8'h00, 16'h0E41);  // LOAD sum
    put(8'h01, 16'h0140);  // ADD i
    put(8'h02, 16'h0D41);  // STORE sum
    put(8'h03, 16'h0E40);  // LOAD i
    put(8'h04, 16'h0242);  // SUB 1
    put(8'h05, 16'h0D40);  // STORE i
    put(8'h06, 16'h0242);  // SUB 1
    put(8'h07, 16'h0A00);  // JMPGEZ loop
    put(8'h08, 16'h0E41);  // LOAD sum
    put(8'h09, 16'h0C00);  // HALT
    put(8'h40, 16'd100);
    put(8'h41, 16'd0);
    put(8'h42, 16'd1);
    repeat (2) @(negedge clk);
    chk("R1 restart clears halted", 32'(halted), 32'd0);
    chk("R1 restart clears acc", 32'(acc_out), 32'd0);
    rst = 1'b0;
    run_until_halt(20000, "R11");
    chk("R11 sum result", 32'(acc_out), 32'd5050);
    compare_mem("R11 memory image");
    chk("R11 loop counter", 32'(mem[8'h40]), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule